// File: doc/BRIEF.md
# Bit-Serial Mantissa Aligner with Pointer-Held Sign Extension

This block lines up a group of floating-point mantissas to a shared exponent without a barrel shifter. Each incoming mantissa comes as a sign and a magnitude, where the magnitude already includes the hidden bit. It is converted to two's complement, and its word is stored in a small circular buffer next to a per-entry exponent offset. A serializer then reads the word one bit per clock, starting with the most significant bit.

The right shift comes from a read pointer that stays on the sign position for offset+1 cycles before it walks toward the LSB. Holding the pointer there repeats the sign bit, which is an arithmetic right shift of the serial stream. A length input sets how many bits each mantissa produces. When that count is reached, the serializer drops the remaining low bits and moves on to the next stored mantissa. If the pointer runs past the LSB before the count is reached, it emits zeros.

Top module: `fifo_mant_aligner`

## Requirements
- R1: The block converts the sign and magnitude on the write port to a two's-complement word of MANT_W+1 bits before storing it. The value is the magnitude when wr_sign is 0 and its negation when wr_sign is 1, so a negative zero is stored as all zeros.
- R2: While ser_valid is high, the block emits one bit per cycle on ser_bit, most significant first. ser_first marks the first bit of a word and ser_last marks its final bit. Both flags are low whenever ser_valid is low.
- R3: The first offset+1 bits of each word equal the sign bit of the stored two's-complement word.
- R4: After the sign bits, the block emits the stored bits below the sign, from next-highest down to bit 0, and then zeros. The word of L bits therefore equals the top L bits of the stored word, placed at the top of a wide field and arithmetically shifted right by the offset.
- R5: The length L of a word is the value of out_len in the cycle the word is taken from the buffer. Changing out_len while the word is being emitted does not change that word. out_len must stay within MIN_LEN..MAX_LEN (2..12 by default).
- R6: If the offset is greater than or equal to L, every bit of the word is the sign bit.
- R7: wr_ready is low exactly when DEPTH mantissas are waiting in the buffer. A write offered while wr_ready is low is dropped.
- R8: When another mantissa is waiting, its first bit follows the previous word's last bit in the very next cycle. When nothing is waiting and no word is in progress, ser_valid is low.
- R9: A mantissa accepted at a rising edge into an empty, idle block shows its first bit right after the following rising edge.
- R10: During and right after reset, ser_valid is low and wr_ready is high.
- R11: Words come out in the order their mantissas were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Offer a mantissa on the write port |
| wr_sign | input | 1 | Sign of the offered mantissa (1 = negative) |
| wr_mag | input | MANT_W | Magnitude including hidden bit |
| wr_offset | input | OFF_W | Exponent offset to the group maximum |
| wr_ready | output | 1 | Buffer can take a mantissa this cycle |
| out_len | input | LEN_W | Serial bits per mantissa (MIN_LEN..MAX_LEN) |
| ser_valid | output | 1 | ser_bit carries a valid bit |
| ser_bit | output | 1 | Serial aligned mantissa bit |
| ser_first | output | 1 | First bit of a word |
| ser_last | output | 1 | Last bit of a word |

## Verification
The checker assumes that out_len always lies between MIN_LEN and MAX_LEN outside reset. Its word-length property also assumes that the length it records one cycle before a first bit is the length the serializer captured. The stimulus keeps out_len within 2..12 from before reset is released onward. It changes out_len only while a word is in flight, never in a cycle where a new word is being loaded. Writes are offered on the ready/valid handshake, and extra writes into a full buffer are offered deliberately to check that they are dropped.

// File: rtl/fma_pkg.sv
package fma_pkg;

   // serializer read-pointer phase
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_HOLD  = 2'd1,
      PH_SHIFT = 2'd2,
      PH_PAD   = 2'd3
   } fma_phase_e;

endpackage

// File: rtl/fma_encode.sv
module fma_encode #(
   parameter int MANT_W = 8,
   localparam int DW = MANT_W + 1
) (
   input  logic              sign_i,
   input  logic [MANT_W-1:0] mag_i,
   output logic [DW-1:0]     word_o
);

   logic [DW-1:0] pos;

   assign pos    = {1'b0, mag_i};
   assign word_o = sign_i ? (~pos + DW'(1)) : pos;

endmodule

// File: rtl/fma_store.sv
module fma_store #(
   parameter int DW    = 9,
   parameter int OFF_W = 4,
   parameter int DEPTH = 4,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [DW-1:0]    din_data,
   input  logic [OFF_W-1:0] din_off,
   output logic             full,
   output logic             empty,
   output logic [DW-1:0]    dout_data,
   output logic [OFF_W-1:0] dout_off
);

   logic [DW-1:0]    slot_d [DEPTH];
   logic [OFF_W-1:0] slot_o [DEPTH];
   logic [AW-1:0]    wp, rp, wp_nx, rp_nx;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wp_nx = wp + AW'(1);
         assign rp_nx = rp + AW'(1);
      end else begin : g_wrap
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) begin
         slot_d[wp] <= din_data;
         slot_o[wp] <= din_off;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         if (do_push && !do_pop)      cnt <= cnt + CW'(1);
         else if (do_pop && !do_push) cnt <= cnt - CW'(1);
      end
   end

   assign dout_data = slot_d[rp];
   assign dout_off  = slot_o[rp];

endmodule

// File: rtl/fma_serial.sv
module fma_serial
   import fma_pkg::*;
#(
   parameter int DW    = 9,
   parameter int OFF_W = 4,
   parameter int LEN_W = 4,
   localparam int PTR_W = (DW > 1) ? $clog2(DW) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             avail,
   input  logic [DW-1:0]    in_data,
   input  logic [OFF_W-1:0] in_off,
   input  logic [LEN_W-1:0] cfg_len,
   output logic             take,
   output logic             bit_o,
   output logic             valid_o,
   output logic             first_o,
   output logic             last_o
);

   fma_phase_e       phase;
   logic [DW-1:0]    word;
   logic [OFF_W-1:0] hold;
   logic [PTR_W-1:0] ptr;
   logic [LEN_W-1:0] cnt, len;

   assign valid_o = (phase != PH_IDLE);
   assign first_o = valid_o && (cnt == '0);
   assign last_o  = valid_o && (cnt == len - LEN_W'(1));
   assign take    = avail && (!valid_o || last_o);
   assign bit_o   = valid_o && (phase != PH_PAD) && word[ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         word  <= '0;
         hold  <= '0;
         ptr   <= '0;
         cnt   <= '0;
         len   <= '0;
      end else if (take) begin
         phase <= PH_HOLD;
         word  <= in_data;
         hold  <= in_off;
         ptr   <= PTR_W'(DW - 1);
         cnt   <= '0;
         len   <= cfg_len;
      end else if (valid_o) begin
         if (last_o) begin
            phase <= PH_IDLE;
         end else begin
            cnt <= cnt + LEN_W'(1);
            unique case (phase)
               PH_HOLD: begin
                  if (hold != '0) begin
                     hold <= hold - OFF_W'(1);
                  end else begin
                     ptr   <= ptr - PTR_W'(1);
                     phase <= PH_SHIFT;
                  end
               end
               PH_SHIFT: begin
                  if (ptr == '0) phase <= PH_PAD;
                  else           ptr   <= ptr - PTR_W'(1);
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/fifo_mant_aligner.sv
module fifo_mant_aligner #(
   parameter int MANT_W  = 8,
   parameter int OFF_W   = 4,
   parameter int DEPTH   = 4,
   parameter int MIN_LEN = 2,
   parameter int MAX_LEN = 12,
   localparam int LEN_W  = $clog2(MAX_LEN + 1),
   localparam int DW     = MANT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic              wr_sign,
   input  logic [MANT_W-1:0] wr_mag,
   input  logic [OFF_W-1:0]  wr_offset,
   output logic              wr_ready,
   input  logic [LEN_W-1:0]  out_len,
   output logic              ser_valid,
   output logic              ser_bit,
   output logic              ser_first,
   output logic              ser_last
);

   initial begin
      if (MANT_W < 1)         $fatal(1, "MANT_W must be at least 1");
      if (OFF_W < 1)          $fatal(1, "OFF_W must be at least 1");
      if (DEPTH < 2)          $fatal(1, "DEPTH must be at least 2");
      if (MIN_LEN < 2)        $fatal(1, "MIN_LEN must be at least 2");
      if (MAX_LEN < MIN_LEN)  $fatal(1, "MAX_LEN below MIN_LEN");
   end

   logic [DW-1:0]    enc_word;
   logic [DW-1:0]    q_data;
   logic [OFF_W-1:0] q_off;
   logic             q_full, q_empty, q_pop;

   fma_encode #(.MANT_W(MANT_W)) u_enc (
      .sign_i (wr_sign),
      .mag_i  (wr_mag),
      .word_o (enc_word)
   );

   fma_store #(.DW(DW), .OFF_W(OFF_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_valid),
      .pop       (q_pop),
      .din_data  (enc_word),
      .din_off   (wr_offset),
      .full      (q_full),
      .empty     (q_empty),
      .dout_data (q_data),
      .dout_off  (q_off)
   );

   fma_serial #(.DW(DW), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .avail   (!q_empty),
      .in_data (q_data),
      .in_off  (q_off),
      .cfg_len (out_len),
      .take    (q_pop),
      .bit_o   (ser_bit),
      .valid_o (ser_valid),
      .first_o (ser_first),
      .last_o  (ser_last)
   );

   assign wr_ready = !q_full;

endmodule

// File: rtl/fma_checker.sv
module fma_checker #(
   parameter int DEPTH   = 4,
   parameter int LEN_W   = 4,
   parameter int MIN_LEN = 2,
   parameter int MAX_LEN = 12,
   localparam int OCC_W  = $clog2(DEPTH + 2) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_valid,
   input logic             wr_ready,
   input logic [LEN_W-1:0] out_len,
   input logic             ser_valid,
   input logic             ser_first,
   input logic             ser_last
);

   logic [OCC_W-1:0] occ;
   logic [LEN_W-1:0] len_q, wlen, bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ   <= '0;
         len_q <= '0;
         wlen  <= '0;
         bcnt  <= '0;
      end else begin
         occ <= occ + OCC_W'(wr_valid && wr_ready) - OCC_W'(ser_valid && ser_first);
         len_q <= out_len;
         if (ser_valid) begin
            if (ser_first) begin
               wlen <= len_q;
               bcnt <= LEN_W'(1);
            end else begin
               bcnt <= bcnt + LEN_W'(1);
            end
         end
      end
   end

   assert_len_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_len >= LEN_W'(MIN_LEN)) && (out_len <= LEN_W'(MAX_LEN)));

   assert_word_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_valid && !ser_first) |-> (ser_last == (bcnt == wlen - LEN_W'(1))));

   assert_first_not_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_valid && ser_first) |-> !ser_last);

   assert_flags_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_valid |-> (!ser_first && !ser_last));

   assert_word_continues_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_valid && !ser_last) |=> (ser_valid && !ser_first));

   assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (occ < OCC_W'(DEPTH)) |-> wr_ready);

   assert_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_valid && ser_last && occ != '0) |=> (ser_valid && ser_first));

   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0 && (!ser_valid || ser_last)) |=> !ser_valid);

endmodule

bind fifo_mant_aligner fma_checker #(
   .DEPTH   (DEPTH),
   .LEN_W   (LEN_W),
   .MIN_LEN (MIN_LEN),
   .MAX_LEN (MAX_LEN)
) u_fma_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_valid  (wr_valid),
   .wr_ready  (wr_ready),
   .out_len   (out_len),
   .ser_valid (ser_valid),
   .ser_first (ser_first),
   .ser_last  (ser_last)
);

// File: tb/tb_fifo_mant_aligner.sv
module tb_fifo_mant_aligner;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_valid = 1'b0;
   logic       wr_sign = 1'b0;
   logic [7:0] wr_mag = '0;
   logic [3:0] wr_offset = '0;
   logic       wr_ready;
   logic [3:0] out_len = 4'd12;
   logic       ser_valid, ser_bit, ser_first, ser_last;

   always #4 clk = ~clk;

   fifo_mant_aligner dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sign(wr_sign),
      .wr_mag(wr_mag), .wr_offset(wr_offset), .wr_ready(wr_ready),
      .out_len(out_len), .ser_valid(ser_valid), .ser_bit(ser_bit),
      .ser_first(ser_first), .ser_last(ser_last)
   );

   // {sign, magnitude[7:0], offset[3:0], length[3:0]}
   localparam logic [16:0] VEC [12] = '{
      {1'b0, 8'hB5, 4'd0,  4'd12},
      {1'b1, 8'hB5, 4'd0,  4'd12},
      {1'b0, 8'h80, 4'd3,  4'd8},
      {1'b1, 8'h9C, 4'd3,  4'd8},
      {1'b1, 8'h01, 4'd5,  4'd12},
      {1'b0, 8'hFF, 4'd2,  4'd2},
      {1'b1, 8'h00, 4'd0,  4'd12},
      {1'b1, 8'h80, 4'd12, 4'd6},
      {1'b0, 8'hC3, 4'd15, 4'd12},
      {1'b1, 8'hAA, 4'd1,  4'd10},
      {1'b0, 8'h7F, 4'd7,  4'd9},
      {1'b1, 8'hF0, 4'd11, 4'd12}
   };

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int acc_cyc = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   logic [15:0] gw [64];
   int          gl [64];
   int          gf [64];
   int          glast [64];
   int          ngot = 0;
   logic [15:0] acc = '0;
   int          nb = 0;

   always @(negedge clk) begin
      if (rst_n && ser_valid && ngot < 64) begin
         if (ser_first) begin
            acc = '0;
            nb = 0;
            gf[ngot] = cyc;
         end
         acc = {acc[14:0], ser_bit};
         nb++;
         if (ser_last) begin
            gw[ngot] = acc;
            gl[ngot] = nb;
            glast[ngot] = cyc;
            ngot++;
         end
      end
   end

   function automatic logic [15:0] model(input bit s, input logic [7:0] m,
                                         input int off, input int len);
      logic signed [8:0]  w;
      logic signed [31:0] e;
      w = s ? -$signed({1'b0, m}) : $signed({1'b0, m});
      e = {w, 23'b0};
      e = e >>> off;
      return 16'($unsigned(e) >> (32 - len));
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at posedge+2; returns at posedge+2 after the accepting edge
   task automatic do_write(input bit s, input logic [7:0] m, input logic [3:0] off);
      bit rdy;
      wr_valid  = 1'b1;
      wr_sign   = s;
      wr_mag    = m;
      wr_offset = off;
      forever begin
         @(negedge clk);
         rdy = wr_ready;
         @(posedge clk);
         if (rdy) break;
      end
      #2;
      wr_valid = 1'b0;
      acc_cyc  = cyc;
   endtask

   task automatic wait_words(input int n);
      while (ngot < n && !done) @(posedge clk);
      #2;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   logic [16:0] v;
   logic [15:0] ev;
   int          base;
   string       tag;

   initial begin
      // R10: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!ser_valid, "R10 ser_valid in reset", 32'(ser_valid), 0);
      chk(wr_ready, "R10 wr_ready in reset", 32'(wr_ready), 1);
      @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk(!ser_valid, "R10 ser_valid after reset", 32'(ser_valid), 0);
      chk(wr_ready, "R10 wr_ready after reset", 32'(wr_ready), 1);
      @(posedge clk);
      #2;

      // table walk: one mantissa at a time against the shift-and-truncate model
      for (int i = 0; i < 12; i++) begin
         v = VEC[i];
         out_len = v[3:0];
         base = ngot;
         do_write(v[16], v[15:8], v[7:4]);
         wait_words(base + 1);
         if (i == 0)
            chk(gf[base] == acc_cyc + 1, "R9 first-bit latency", 32'(gf[base]), 32'(acc_cyc + 1));
         ev = model(v[16], v[15:8], int'(v[7:4]), int'(v[3:0]));
         if (v[7:4] >= v[3:0])    tag = "R6 all sign bits";
         else if (v[16])          tag = "R1 R3 R4 negative word";
         else                     tag = "R2 R3 R4 positive word";
         chk(gw[base] == ev, tag, 32'(gw[base]), 32'(ev));
         chk(gl[base] == int'(v[3:0]), "R5 word length", 32'(gl[base]), 32'(v[3:0]));
      end

      // R8: quiet once drained
      repeat (2) @(negedge clk);
      chk(!ser_valid, "R8 idle when empty", 32'(ser_valid), 0);
      @(posedge clk);
      #2;

      // R7 / R11 / R8: fill the buffer, offer an extra write while full
      out_len = 4'd12;
      base = ngot;
      for (int k = 0; k < 5; k++)
         do_write(k[0], 8'h11 * 8'(k + 3), 4'(k));
      chk(!wr_ready, "R7 full after DEPTH waiting", 32'(wr_ready), 0);
      wr_valid  = 1'b1;
      wr_sign   = 1'b0;
      wr_mag    = 8'hEE;
      wr_offset = 4'd0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!wr_ready, "R7 ready low while full", 32'(wr_ready), 0);
      end
      @(posedge clk);
      #2 wr_valid = 1'b0;
      wait_words(base + 5);
      repeat (30) @(posedge clk);
      #2;
      chk(ngot == base + 5, "R7 write while full dropped", 32'(ngot - base), 5);
      for (int k = 0; k < 5; k++) begin
         ev = model(k[0], 8'h11 * 8'(k + 3), k, 12);
         chk(gw[base + k] == ev, "R11 order and value", 32'(gw[base + k]), 32'(ev));
      end
      for (int k = 0; k < 4; k++)
         chk(gf[base + k + 1] == glast[base + k] + 1, "R8 back-to-back words",
             32'(gf[base + k + 1]), 32'(glast[base + k] + 1));

      // R5: length change during a word does not affect it
      out_len = 4'd12;
      base = ngot;
      do_write(1'b1, 8'h5A, 4'd1);
      repeat (4) @(posedge clk);
      #2 out_len = 4'd2;
      wait_words(base + 1);
      ev = model(1'b1, 8'h5A, 1, 12);
      chk(gl[base] == 12, "R5 length held mid-word", 32'(gl[base]), 12);
      chk(gw[base] == ev, "R5 value held mid-word", 32'(gw[base]), 32'(ev));
      do_write(1'b0, 8'h5A, 4'd1);
      wait_words(base + 2);
      ev = model(1'b0, 8'h5A, 1, 2);
      chk(gl[base + 1] == 2, "R5 new length applies", 32'(gl[base + 1]), 2);
      chk(gw[base + 1] == ev, "R5 short word value", 32'(gw[base + 1]), 32'(ev));

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule